// File: doc/BRIEF.md
# Host-Port Resource Decoder with Bypass Sequencing

This block sits on the controlling-processor side of a bidirectional buffer made of two FIFOs, one for each direction. The host presents a 3-bit address, a chip select, a read/write line and an enable on its own clock. The decoder turns each access into one of six actions. It can load the outgoing FIFO, take a word from the incoming FIFO, exchange a word over the direct bypass path, or read or write one of four programmable-flag offset registers. The FIFO storage, the flag arithmetic and the pad drivers live elsewhere. For those, this block only produces registered strobes, write data, a drive enable for the host data lines, and the offset values.

The host alone decides when bypass mode begins and ends. Selecting the bypass address enters bypass mode, and selecting the FIFO address leaves it. A mode flag follows on the host clock and is resynchronised into the far-port clock domain, where it tells the far device to use its bypass controls. Each direction of the bypass path holds exactly one word. A word is kept until the reading side takes it, and the words cross between the two clock domains through toggle handshakes. The FIFO strobes are never raised while the bypass path is in use, so FIFO contents and pointers are untouched.

Top module: `hrd_top`

## Requirements
- R1: While `h_cs` is low at a host clock edge, that edge leaves `h_drive`, `fifo_out_wr`, `fifo_in_rd` and every offset register low or unchanged for the following cycle.
- R2: An enabled access at address 000 reaches the FIFO path. A write raises `fifo_out_wr` for one cycle after the access edge, with `fifo_out_wdata` equal to the written word. A read loads `fifo_in_rdata` into `h_rdata` at the access edge and raises `fifo_in_rd` for the following cycle.
- R3: Addresses with bit 2 set reach the offset registers, using the low two bits: 00 outgoing almost-empty, 01 outgoing almost-full, 10 incoming almost-empty, 11 incoming almost-full. An enabled write with `h_cs` high takes effect on that edge, and a read returns the register zero-extended.
- R4: After reset, all four offsets equal 8. `h_byp_mode`, `f_byp`, `h_drive`, both FIFO strobes and `f_rx_avail` are 0, and `f_tx_space` is 1.
- R5: An access to address 001 with `h_cs` high sets `h_byp_mode` on that edge, and one to address 000 clears it. `f_byp` follows `h_byp_mode` through two far-clock flops.
- R6: A host write at 001 fills the host-to-far word. A far read (`f_en`=1, `f_wr`=0) while `f_byp` is high returns it on `f_rdata` after the far edge and frees the slot. A host write while the slot is full is ignored, and the held word is kept.
- R7: A far write while `f_byp` is high fills the far-to-host word. A host read at 001 returns it and frees the slot. A host read of an empty slot returns the last held word.
- R8: The FIFO strobes are never high while `h_byp_mode` is high, and bypass or offset accesses never raise them.
- R9: Far accesses while `f_byp` is low have no effect: `f_rdata` holds, and no word is stored.
- R10: Reads at addresses 010 and 011 return zero, and writes there change nothing.
- R11: `h_drive` is high in the cycle after an edge where `h_cs` is high and `h_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| h_clk | input | 1 | Host clock |
| h_rst | input | 1 | Host-domain synchronous reset, active high |
| h_cs | input | 1 | Host chip select |
| h_en | input | 1 | Host access enable |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_addr | input | 3 | Resource address |
| h_wdata | input | 18 | Host write data |
| h_rdata | output | 18 | Host read data (registered) |
| h_drive | output | 1 | Drive enable for host data lines |
| h_byp_mode | output | 1 | Bypass mode flag, host domain |
| fifo_out_wr | output | 1 | Load strobe for outgoing FIFO |
| fifo_out_wdata | output | 18 | Word for outgoing FIFO |
| fifo_in_rd | output | 1 | Advance strobe for incoming FIFO |
| fifo_in_rdata | input | 18 | Incoming FIFO output register |
| off_out_ae | output | 9 | Outgoing almost-empty offset |
| off_out_af | output | 9 | Outgoing almost-full offset |
| off_in_ae | output | 9 | Incoming almost-empty offset |
| off_in_af | output | 9 | Incoming almost-full offset |
| f_clk | input | 1 | Far-port clock |
| f_rst | input | 1 | Far-domain synchronous reset, active high |
| f_en | input | 1 | Far access enable |
| f_wr | input | 1 | Far 1 = write, 0 = read |
| f_wdata | input | 18 | Far write data |
| f_rdata | output | 18 | Far read data (registered) |
| f_byp | output | 1 | Bypass flag in far domain |
| f_rx_avail | output | 1 | Host-to-far word waiting |
| f_tx_space | output | 1 | Far-to-host slot free |

## Verification
The hardest case to reach is a host write that arrives while the host-to-far slot still holds an unread word. To produce it, the stimulus issues two back-to-back host bypass writes before the far side can react. The scoreboard queue holds only the first word, and the far read must return that word. The reverse direction is driven into an empty-slot read by reading the same word twice, which shows the held value is kept. Far accesses are issued before bypass mode exists, and their lack of effect is shown through a later host bypass read that returns the reset value.

// File: rtl/hrd_pkg.sv
package hrd_pkg;

  typedef enum logic [1:0] {
    RS_FIFO = 2'd0,
    RS_BYP  = 2'd1,
    RS_RSVD = 2'd2,
    RS_OFF  = 2'd3
  } rsrc_e;

  localparam int OFF_NUM = 4;

  typedef struct packed {
    rsrc_e      rsrc;
    logic [1:0] off_idx;
    logic       rd;
    logic       wr;
    logic       sel_byp;
    logic       sel_fifo;
  } hrd_access_t;

  function automatic rsrc_e classify(input logic [2:0] a);
    if (a[2])             return RS_OFF;
    else if (a[1])        return RS_RSVD;
    else if (a[0])        return RS_BYP;
    else                  return RS_FIFO;
  endfunction

endpackage

// File: rtl/hrd_sync.sv
module hrd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hrd_decode.sv
module hrd_decode
  import hrd_pkg::*;
#(
  parameter int NOFF = OFF_NUM
) (
  input  logic            cs,
  input  logic            en,
  input  logic            wr,
  input  logic [2:0]      addr,
  output hrd_access_t     acc,
  output logic            fifo_wr,
  output logic            fifo_rd,
  output logic            byp_wr,
  output logic            byp_rd,
  output logic [NOFF-1:0] off_wr
);
  logic rd_any, wr_any;
  rsrc_e kind;

  assign kind   = classify(addr);
  assign rd_any = cs && en && !wr;
  assign wr_any = cs && en && wr;

  always_comb begin
    acc.rsrc     = kind;
    acc.off_idx  = addr[1:0];
    acc.rd       = rd_any;
    acc.wr       = wr_any;
    acc.sel_byp  = cs && (kind == RS_BYP);
    acc.sel_fifo = cs && (kind == RS_FIFO);
  end

  assign fifo_wr = wr_any && (kind == RS_FIFO);
  assign fifo_rd = rd_any && (kind == RS_FIFO);
  assign byp_wr  = wr_any && (kind == RS_BYP);
  assign byp_rd  = rd_any && (kind == RS_BYP);

  for (genvar i = 0; i < NOFF; i++) begin : g_offsel
    assign off_wr[i] = wr_any && (kind == RS_OFF) && (addr[1:0] == i[1:0]);
  end
endmodule

// File: rtl/hrd_offset_regs.sv
module hrd_offset_regs #(
  parameter int NUM     = 4,
  parameter int OW      = 9,
  parameter int RST_VAL = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM-1:0]          wr_en,
  input  logic [OW-1:0]           wdata,
  output logic [NUM-1:0][OW-1:0]  vals
);
  for (genvar i = 0; i < NUM; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)           vals[i] <= OW'(RST_VAL);
      else if (wr_en[i]) vals[i] <= wdata;
    end

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(wr_en[i])) |-> $stable(vals[i])); // R3
  end
endmodule

// File: rtl/hrd_bypass_word.sv
module hrd_bypass_word #(
  parameter int W      = 18,
  parameter int STAGES = 2
) (
  input  logic         w_clk,
  input  logic         w_rst,
  input  logic         w_push,
  input  logic [W-1:0] w_data,
  output logic         w_full,
  input  logic         r_clk,
  input  logic         r_rst,
  input  logic         r_pop,
  output logic         r_valid,
  output logic [W-1:0] r_data
);
  logic         wtog, rtog, wtog_s, rtog_s;
  logic [W-1:0] hold;

  hrd_sync #(.STAGES(STAGES)) u_w2r (.clk(r_clk), .rst(r_rst), .d(wtog), .q(wtog_s));
  hrd_sync #(.STAGES(STAGES)) u_r2w (.clk(w_clk), .rst(w_rst), .d(rtog), .q(rtog_s));

  assign w_full  = wtog ^ rtog_s;
  assign r_valid = wtog_s ^ rtog;
  assign r_data  = hold;

  always_ff @(posedge w_clk) begin
    if (w_rst) begin
      wtog <= 1'b0;
      hold <= '0;
    end else if (w_push && !w_full) begin
      wtog <= ~wtog;
      hold <= w_data;
    end
  end

  always_ff @(posedge r_clk) begin
    if (r_rst)                 rtog <= 1'b0;
    else if (r_pop && r_valid) rtog <= ~rtog;
  end

  AST_FULL_KEEPS_WORD: assert property (@(posedge w_clk) disable iff (w_rst)
    (!$past(w_rst) && $past(w_full) && w_full) |-> $stable(hold)); // R6

  AST_VALID_WORD_STABLE: assert property (@(posedge r_clk) disable iff (r_rst)
    (!$past(r_rst) && $past(r_valid) && r_valid) |-> $stable(r_data)); // R6
endmodule

// File: rtl/hrd_top.sv
module hrd_top
  import hrd_pkg::*;
#(
  parameter int W        = 18,
  parameter int OW       = 9,
  parameter int OFF_RST  = 8,
  parameter int SYNC_STG = 2
) (
  input  logic          h_clk,
  input  logic          h_rst,
  input  logic          h_cs,
  input  logic          h_en,
  input  logic          h_wr,
  input  logic [2:0]    h_addr,
  input  logic [W-1:0]  h_wdata,
  output logic [W-1:0]  h_rdata,
  output logic          h_drive,
  output logic          h_byp_mode,
  output logic          fifo_out_wr,
  output logic [W-1:0]  fifo_out_wdata,
  output logic          fifo_in_rd,
  input  logic [W-1:0]  fifo_in_rdata,
  output logic [OW-1:0] off_out_ae,
  output logic [OW-1:0] off_out_af,
  output logic [OW-1:0] off_in_ae,
  output logic [OW-1:0] off_in_af,
  input  logic          f_clk,
  input  logic          f_rst,
  input  logic          f_en,
  input  logic          f_wr,
  input  logic [W-1:0]  f_wdata,
  output logic [W-1:0]  f_rdata,
  output logic          f_byp,
  output logic          f_rx_avail,
  output logic          f_tx_space
);
  localparam int NOFF = OFF_NUM;

  hrd_access_t           acc;
  logic                  dec_fifo_wr, dec_fifo_rd, dec_byp_wr, dec_byp_rd;
  logic [NOFF-1:0]       dec_off_wr;
  logic [NOFF-1:0][OW-1:0] offs;
  logic [W-1:0]          off_ext;
  logic [W-1:0]          h2f_data, f2h_data;
  logic                  h2f_full, f2h_valid, f2h_full;

  hrd_decode #(.NOFF(NOFF)) u_dec (
    .cs(h_cs), .en(h_en), .wr(h_wr), .addr(h_addr), .acc(acc),
    .fifo_wr(dec_fifo_wr), .fifo_rd(dec_fifo_rd),
    .byp_wr(dec_byp_wr), .byp_rd(dec_byp_rd), .off_wr(dec_off_wr)
  );

  hrd_offset_regs #(.NUM(NOFF), .OW(OW), .RST_VAL(OFF_RST)) u_off (
    .clk(h_clk), .rst(h_rst), .wr_en(dec_off_wr),
    .wdata(h_wdata[OW-1:0]), .vals(offs)
  );

  assign off_out_ae = offs[0];
  assign off_out_af = offs[1];
  assign off_in_ae  = offs[2];
  assign off_in_af  = offs[3];

  always_comb begin
    off_ext = '0;
    off_ext[OW-1:0] = offs[acc.off_idx];
  end

  // host -> far one-word path
  hrd_bypass_word #(.W(W), .STAGES(SYNC_STG)) u_h2f (
    .w_clk(h_clk), .w_rst(h_rst), .w_push(dec_byp_wr), .w_data(h_wdata), .w_full(h2f_full),
    .r_clk(f_clk), .r_rst(f_rst), .r_pop(f_byp && f_en && !f_wr),
    .r_valid(f_rx_avail), .r_data(h2f_data)
  );

  // far -> host one-word path
  hrd_bypass_word #(.W(W), .STAGES(SYNC_STG)) u_f2h (
    .w_clk(f_clk), .w_rst(f_rst), .w_push(f_byp && f_en && f_wr), .w_data(f_wdata), .w_full(f2h_full),
    .r_clk(h_clk), .r_rst(h_rst), .r_pop(dec_byp_rd),
    .r_valid(f2h_valid), .r_data(f2h_data)
  );

  assign f_tx_space = !f2h_full;

  hrd_sync #(.STAGES(SYNC_STG)) u_flag (.clk(f_clk), .rst(f_rst), .d(h_byp_mode), .q(f_byp));

  // host-domain registered outputs
  always_ff @(posedge h_clk) begin
    if (h_rst) begin
      h_rdata        <= '0;
      h_drive        <= 1'b0;
      h_byp_mode     <= 1'b0;
      fifo_out_wr    <= 1'b0;
      fifo_out_wdata <= '0;
      fifo_in_rd     <= 1'b0;
    end else begin
      h_drive     <= h_cs && !h_wr;
      fifo_out_wr <= dec_fifo_wr;
      fifo_in_rd  <= dec_fifo_rd;
      if (dec_fifo_wr) fifo_out_wdata <= h_wdata;
      if (acc.sel_byp)       h_byp_mode <= 1'b1;
      else if (acc.sel_fifo) h_byp_mode <= 1'b0;
      if (acc.rd) begin
        unique case (acc.rsrc)
          RS_FIFO: h_rdata <= fifo_in_rdata;
          RS_BYP:  h_rdata <= f2h_data;
          RS_OFF:  h_rdata <= off_ext;
          default: h_rdata <= '0;
        endcase
      end
    end
  end

  // far-domain read register
  always_ff @(posedge f_clk) begin
    if (f_rst) f_rdata <= '0;
    else if (f_byp && f_en && !f_wr && f_rx_avail) f_rdata <= h2f_data;
  end

  AST_IDLE_WHEN_DESELECTED: assert property (@(posedge h_clk) disable iff (h_rst)
    (!$past(h_rst) && !$past(h_cs)) |-> (!h_drive && !fifo_out_wr && !fifo_in_rd)); // R1

  AST_FIFO_QUIET_IN_BYP: assert property (@(posedge h_clk) disable iff (h_rst)
    (fifo_out_wr || fifo_in_rd) |-> !h_byp_mode); // R8

  AST_MODE_ENTER: assert property (@(posedge h_clk) disable iff (h_rst)
    (!$past(h_rst) && $past(h_cs) && ($past(h_addr) == 3'b001)) |-> h_byp_mode); // R5

  AST_MODE_LEAVE: assert property (@(posedge h_clk) disable iff (h_rst)
    (!$past(h_rst) && $past(h_cs) && ($past(h_addr) == 3'b000)) |-> !h_byp_mode); // R5

  AST_FAR_IGNORED: assert property (@(posedge f_clk) disable iff (f_rst)
    (!$past(f_rst) && !$past(f_byp)) |-> $stable(f_rdata)); // R9

  AST_DRIVE_ON_READ: assert property (@(posedge h_clk) disable iff (h_rst)
    (!$past(h_rst) && $past(h_cs) && !$past(h_wr)) |-> h_drive); // R11
endmodule

// File: tb/hrd_top_tb_top.sv
module hrd_top_tb_top;
  localparam int W  = 18;
  localparam int OW = 9;

  logic          h_clk = 0, f_clk = 0;
  logic          h_rst, f_rst;
  logic          h_cs, h_en, h_wr;
  logic [2:0]    h_addr;
  logic [W-1:0]  h_wdata, h_rdata, fifo_out_wdata, fifo_in_rdata, f_wdata, f_rdata;
  logic          h_drive, h_byp_mode, fifo_out_wr, fifo_in_rd;
  logic [OW-1:0] off_out_ae, off_out_af, off_in_ae, off_in_af;
  logic          f_en, f_wr, f_byp, f_rx_avail, f_tx_space;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [W-1:0] exp_q[$];

  always #5 h_clk = ~h_clk;
  always #7 f_clk = ~f_clk;

  hrd_top dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // host access; called at a host negedge, returns at the negedge after the access edge
  task automatic hacc(input logic cs, input logic wr, input logic [2:0] a, input logic [W-1:0] d);
    h_cs = cs; h_en = 1; h_wr = wr; h_addr = a; h_wdata = d;
    @(posedge h_clk); @(negedge h_clk);
    h_cs = 0; h_en = 0; h_wr = 0;
  endtask

  task automatic facc(input logic wr, input logic [W-1:0] d);
    @(negedge f_clk);
    f_en = 1; f_wr = wr; f_wdata = d;
    @(posedge f_clk); @(negedge f_clk);
    f_en = 0; f_wr = 0;
  endtask

  task automatic hwait(input int n);
    repeat (n) @(negedge h_clk);
  endtask

  // driver: host bypass write pushes expected word
  task automatic drv_byp_write(input logic [W-1:0] d, input bit accepted);
    hacc(1, 1, 3'b001, d);
    if (accepted) exp_q.push_back(d);
  endtask

  // monitor: far read pops expected word and compares
  task automatic mon_far_read();
    logic [W-1:0] e;
    for (int i = 0; i < 20 && !f_rx_avail; i++) @(negedge f_clk);
    facc(0, '0);
    if (exp_q.size() == 0) begin
      chk("R6 scoreboard underflow", 1, 0);
    end else begin
      e = exp_q.pop_front();
      chk("R6 far read word", f_rdata, e);
    end
  endtask

  initial begin
    h_rst = 1; f_rst = 1; h_cs = 0; h_en = 0; h_wr = 0; h_addr = 0; h_wdata = 0;
    fifo_in_rdata = 0; f_en = 0; f_wr = 0; f_wdata = 0;
    repeat (4) @(posedge f_clk);
    @(negedge h_clk); h_rst = 0; f_rst = 0;
    @(negedge h_clk);

    // R4 reset state
    chk("R4 off_out_ae", off_out_ae, 8);
    chk("R4 off_out_af", off_out_af, 8);
    chk("R4 off_in_ae", off_in_ae, 8);
    chk("R4 off_in_af", off_in_af, 8);
    chk("R4 mode/flag", {h_byp_mode, f_byp, h_drive, fifo_out_wr, fifo_in_rd}, 0);
    chk("R4 far status", {f_rx_avail, f_tx_space}, 2'b01);

    // R9 far access before bypass: no effect
    facc(1, 18'h2AAAA);
    facc(0, '0);
    chk("R9 far rdata held", f_rdata, 0);
    chk("R9 tx space kept", f_tx_space, 1);
    @(negedge h_clk); hwait(8);

    // R1 deselected accesses
    hacc(0, 1, 3'b100, 18'h5);
    chk("R1 offset unchanged", off_out_ae, 8);
    chk("R1 strobes low", {h_drive, fifo_out_wr, fifo_in_rd}, 0);
    hacc(0, 0, 3'b000, 0);
    chk("R1 no read strobe", {h_drive, fifo_in_rd}, 0);

    // R2 FIFO path
    hacc(1, 1, 3'b000, 18'h1234F);
    chk("R2 fifo_out_wr", fifo_out_wr, 1);
    chk("R2 fifo_out_wdata", fifo_out_wdata, 18'h1234F);
    chk("R11 drive low on write", h_drive, 0);
    hwait(1);
    chk("R2 write strobe one cycle", fifo_out_wr, 0);
    fifo_in_rdata = 18'h3C0A5;
    hacc(1, 0, 3'b000, 0);
    chk("R2 read data", h_rdata, 18'h3C0A5);
    chk("R2 fifo_in_rd", fifo_in_rd, 1);
    chk("R11 drive on read", h_drive, 1);
    hwait(1);
    chk("R2 read strobe one cycle", fifo_in_rd, 0);

    // R3 offsets
    hacc(1, 1, 3'b100, 18'h011);
    hacc(1, 1, 3'b101, 18'h122);
    hacc(1, 1, 3'b110, 18'h033);
    hacc(1, 1, 3'b111, 18'h1F4);
    chk("R3 out ae", off_out_ae, 9'h011);
    chk("R3 out af", off_out_af, 9'h122);
    chk("R3 in ae", off_in_ae, 9'h033);
    chk("R3 in af", off_in_af, 9'h1F4);
    chk("R8 no strobe on offset write", fifo_out_wr, 0);
    hacc(1, 0, 3'b110, 0);
    chk("R3 read back", h_rdata, 18'h033);

    // R10 reserved addresses
    hacc(1, 1, 3'b011, 18'h3FFFF);
    hacc(1, 0, 3'b010, 0);
    chk("R10 read zero", h_rdata, 0);
    chk("R10 offsets intact", {off_out_ae, off_out_af, off_in_ae, off_in_af},
        {9'h011, 9'h122, 9'h033, 9'h1F4});

    // R5 enter bypass; R7 empty read returns reset value (R9 nothing stored)
    hacc(1, 0, 3'b001, 0);
    chk("R5 mode set", h_byp_mode, 1);
    chk("R9 nothing stored", h_rdata, 0);
    repeat (4) @(negedge f_clk);
    chk("R5 far flag set", f_byp, 1);
    @(negedge h_clk);

    // R6 host->far, with full-slot write ignored
    drv_byp_write(18'h0BEEF, 1);
    chk("R8 no strobe on bypass write", fifo_out_wr, 0);
    drv_byp_write(18'h15555, 0);
    mon_far_read();
    @(negedge h_clk); hwait(6);
    drv_byp_write(18'h2468A, 1);
    mon_far_read();
    chk("R6 slot drained", f_rx_avail, 0);

    // R7 far->host
    facc(1, 18'h13579);
    @(negedge h_clk); hwait(6);
    hacc(1, 0, 3'b001, 0);
    chk("R7 host read word", h_rdata, 18'h13579);
    hwait(6);
    hacc(1, 0, 3'b001, 0);
    chk("R7 empty read keeps last", h_rdata, 18'h13579);
    for (int i = 0; i < 20 && !f_tx_space; i++) @(negedge f_clk);
    chk("R7 slot freed", f_tx_space, 1);
    facc(1, 18'h00ACE);
    @(negedge h_clk); hwait(6);
    hacc(1, 0, 3'b001, 0);
    chk("R7 second word", h_rdata, 18'h00ACE);

    // R5 leave bypass
    fifo_in_rdata = 18'h00777;
    hacc(1, 0, 3'b000, 0);
    chk("R5 mode cleared", h_byp_mode, 0);
    chk("R8 fifo read after exit", fifo_in_rd, 1);
    repeat (4) @(negedge f_clk);
    chk("R5 far flag cleared", f_byp, 0);
    chk("R6 scoreboard empty", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule